// File: doc/BRIEF.md
# Reset Sequencer with Vector Selection

This block produces the reset for a small processor core. Five kinds of request can start a reset sequence: power-on, an illegal address access, a watchdog expiry, an oscillator-monitor fault, and the shared reset pin being pulled low from outside. The fault sources are computed elsewhere and arrive as request inputs. Once a sequence starts, the block pulls the open-drain reset pin low for a fixed number of clocks and then lets it go. It waits a further settling window and samples the pin level through a synchronizer. That sample, together with sticky records of watchdog and oscillator faults, picks the vector that the core fetches when it leaves reset.

The internal core reset rises in the same cycle a request is seen, even before the state register moves. It stays high for the whole drive and settle sequence. If something outside is still holding the pin low when the settling window closes, the core reset stays high until the synchronized pin reads high again. The vector code is registered at the close of the settling window and holds steady while the core reset falls. The fault records are cleared on the clock edge at which the sequence ends.

Top module: `reset_vector_seq`

## Requirements
- R1: With the sequencer idle, any of the four request inputs high, a pending fault record, or a synchronized pin level of 0 starts a sequence, and `core_rst_o` is 1 in that same cycle.
- R2: `pin_drive_o` (1 = pull the pin low) is 1 for exactly DRIVE_CYC consecutive cycles, starting on the cycle after the edge that starts the sequence.
- R3: After the drive ends, a settling window of SETTLE_CYC cycles follows, with `pin_drive_o` at 0 and `core_rst_o` at 1.
- R4: `core_rst_o` is 1 for every cycle of the sequence. If the pin samples high, it falls exactly DRIVE_CYC+SETTLE_CYC cycles after the start edge.
- R5: If the synchronized pin is 0 in the last settling cycle, `core_rst_o` stays 1 until the synchronized pin reads 1. In that case the vector is 2'b00 and any pending fault records are ignored.
- R6: If the pin samples high, `vec_o` is 2'b10 when an oscillator fault is pending, otherwise 2'b01 when a watchdog expiry is pending, otherwise 2'b00. The code 2'b11 never appears. `vec_o` holds its value while `core_rst_o` falls.
- R7: Watchdog and oscillator requests are held in sticky records, including requests that arrive during a sequence. The records clear on the edge where the sequence ends. A request raised in that same exit cycle is kept and starts a new sequence.
- R8: `pin_i` passes through SYNC_STAGES flip-flops before it is used. An external low starts a sequence SYNC_STAGES edges after the pin falls.
- R9: While `rst` is high at a clock edge, the sequencer returns to idle, clears the fault records and sets `vec_o` to 2'b00, with `pin_drive_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer's own state |
| por_req_i | input | 1 | Power-on detected |
| ill_addr_req_i | input | 1 | Illegal address access detected |
| wdog_req_i | input | 1 | Watchdog expiry |
| osc_fail_req_i | input | 1 | Oscillator monitor fault |
| pin_i | input | 1 | Level read back from the reset pin |
| pin_drive_o | output | 1 | 1 = pull the reset pin low |
| core_rst_o | output | 1 | Reset to the core, active high |
| vec_o | output | 2 | Vector code: 00 power-on/illegal/external, 01 watchdog, 10 oscillator fault |

## Verification
The bench builds the block with DRIVE_CYC=12, SETTLE_CYC=6 and SYNC_STAGES=2. With these values a full sequence takes 18 cycles, so many sequences fit into a short run. This short sequence brings within reach the cases that depend on exact timing: a request in the very last settling cycle, an external hold that outlasts the settling window while a fault is pending, and fault requests that arrive partway through the drive phase. A behavioural model in the bench predicts the pin drive, the core reset and the vector for every cycle.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    typedef enum logic [1:0] {
        VEC_EXT  = 2'b00,
        VEC_WDOG = 2'b01,
        VEC_OSC  = 2'b10
    } rvec_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_DRIVE  = 2'b01,
        ST_SETTLE = 2'b10,
        ST_HOLD   = 2'b11
    } rseq_e;

    typedef struct packed {
        logic wdog;
        logic osc;
    } pend_t;

    // Vector choice at the close of the settling window
    function automatic rvec_e pick_vec(logic pin_hi, pend_t p);
        if (!pin_hi) return VEC_EXT;
        if (p.osc)   return VEC_OSC;
        if (p.wdog)  return VEC_WDOG;
        return VEC_EXT;
    endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rsg_pending.sv
module rsg_pending
    import rsg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_wdog,
    input  logic  set_osc,
    input  logic  clear,
    output pend_t pend
);
    pend_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            // a set in the clearing cycle wins
            pend_q.wdog <= (clear ? 1'b0 : pend_q.wdog) | set_wdog;
            pend_q.osc  <= (clear ? 1'b0 : pend_q.osc)  | set_osc;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/rsg_seq.sv
module rsg_seq
    import rsg_pkg::*;
#(
    parameter int DRIVE_CYC  = 516,
    parameter int SETTLE_CYC = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_req,
    input  logic  pin_sync,
    input  pend_t pend,
    output logic  pin_drive,
    output logic  core_rst,
    output rvec_e vec,
    output logic  clear_pend
);
    localparam int MAXC = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DRV_LAST = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_CYC - 1);

    rseq_e          st;
    logic [CW-1:0]  cnt;
    rvec_e          vec_q;
    logic           settle_end;

    assign settle_end = (st == ST_SETTLE) && (cnt == SET_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            vec_q <= VEC_EXT;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start_req) begin
                        st  <= ST_DRIVE;
                        cnt <= '0;
                    end
                end
                ST_DRIVE: begin
                    if (cnt == DRV_LAST) begin
                        st  <= ST_SETTLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (settle_end) begin
                        cnt   <= '0;
                        vec_q <= pick_vec(pin_sync, pend);
                        st    <= pin_sync ? ST_IDLE : ST_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (pin_sync) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pin_drive  = (st == ST_DRIVE);
    assign core_rst   = (st != ST_IDLE) | start_req;
    assign vec        = vec_q;
    assign clear_pend = (settle_end && pin_sync) || ((st == ST_HOLD) && pin_sync);
endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
    import rsg_pkg::*;
#(
    parameter int DRIVE_CYC   = 516,
    parameter int SETTLE_CYC  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_req_i,
    input  logic       ill_addr_req_i,
    input  logic       wdog_req_i,
    input  logic       osc_fail_req_i,
    input  logic       pin_i,
    output logic       pin_drive_o,
    output logic       core_rst_o,
    output logic [1:0] vec_o
);
    logic  pin_sync;
    pend_t pend;
    logic  clear_pend;
    logic  start_req;
    rvec_e vec;

    rsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (pin_sync)
    );

    rsg_pending u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_wdog (wdog_req_i),
        .set_osc  (osc_fail_req_i),
        .clear    (clear_pend),
        .pend     (pend)
    );

    assign start_req = por_req_i | ill_addr_req_i | wdog_req_i | osc_fail_req_i
                     | pend.wdog | pend.osc | ~pin_sync;

    rsg_seq #(.DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .pin_sync   (pin_sync),
        .pend       (pend),
        .pin_drive  (pin_drive_o),
        .core_rst   (core_rst_o),
        .vec        (vec),
        .clear_pend (clear_pend)
    );

    assign vec_o = vec;
endmodule

// File: rtl/rsg_chk.sv
module rsg_chk #(
    parameter int DRIVE_CYC = 516
) (
    input logic       clk,
    input logic       rst,
    input logic       pin_drive,
    input logic       core_rst,
    input logic [1:0] vec,
    input logic       pin_sync
);
    localparam int RW = $clog2(DRIVE_CYC + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)            run <= '0;
        else if (pin_drive) run <= run + 1'b1;
        else                run <= '0;
    end

    assert_drive_len_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drive) |-> (run == RW'(DRIVE_CYC)));

    assert_drive_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run <= RW'(DRIVE_CYC));

    assert_settle_rst_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drive) |-> core_rst);

    assert_drive_in_rst_R4: assert property (@(posedge clk) disable iff (rst)
        pin_drive |-> core_rst);

    assert_release_pin_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> pin_sync);

    assert_vec_code_R6: assert property (@(posedge clk) disable iff (rst)
        vec != 2'b11);

    assert_vec_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |=> $stable(vec));
endmodule

bind reset_vector_seq rsg_chk #(.DRIVE_CYC(DRIVE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_drive (pin_drive_o),
    .core_rst  (core_rst_o),
    .vec       (vec_o),
    .pin_sync  (pin_sync)
);

// File: tb/reset_vector_seq_tb.sv
`timescale 1ns/1ps
module reset_vector_seq_tb;
    localparam int DRV = 12;
    localparam int SET = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_r = 1'b0, ill_r = 1'b0, wd_r = 1'b0, osc_r = 1'b0;
    logic ext_low = 1'b0;
    logic pin;
    logic pin_drive, core_rst;
    logic [1:0] vec;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit armed  = 1'b0;

    always #4 clk = ~clk;

    assign pin = !(pin_drive | ext_low);

    reset_vector_seq #(.DRIVE_CYC(DRV), .SETTLE_CYC(SET), .SYNC_STAGES(2)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .por_req_i      (por_r),
        .ill_addr_req_i (ill_r),
        .wdog_req_i     (wd_r),
        .osc_fail_req_i (osc_r),
        .pin_i          (pin),
        .pin_drive_o    (pin_drive),
        .core_rst_o     (core_rst),
        .vec_o          (vec)
    );

    // behavioural model: 0 idle, 1 drive, 2 settle, 3 hold
    int   ms = 0, mc = 0;
    logic s0 = 1'b1, s1 = 1'b1, mwd = 1'b0, mosc = 1'b0;
    logic [1:0] mvec = 2'b00;

    always @(posedge clk) begin
        int   ns, nc;
        logic npin, start, clr;
        logic [1:0] nv;
        if (rst) begin
            ms = 0; mc = 0; s0 = 1'b1; s1 = 1'b1; mwd = 1'b0; mosc = 1'b0; mvec = 2'b00;
        end else begin
            npin  = !((ms == 1) || ext_low);
            start = por_r | ill_r | wd_r | osc_r | mwd | mosc | !s1;
            ns = ms; nc = mc; nv = mvec; clr = 1'b0;
            if (ms == 0) begin
                if (start) begin ns = 1; nc = 0; end
            end else if (ms == 1) begin
                if (mc == DRV - 1) begin ns = 2; nc = 0; end else nc = mc + 1;
            end else if (ms == 2) begin
                if (mc == SET - 1) begin
                    nc = 0;
                    if (!s1) begin ns = 3; nv = 2'b00; end
                    else begin
                        ns = 0; clr = 1'b1;
                        nv = mosc ? 2'b10 : (mwd ? 2'b01 : 2'b00);
                    end
                end else nc = mc + 1;
            end else begin
                if (s1) begin ns = 0; clr = 1'b1; end
            end
            mwd  = (clr ? 1'b0 : mwd)  | wd_r;
            mosc = (clr ? 1'b0 : mosc) | osc_r;
            s1 = s0; s0 = npin;
            ms = ns; mc = nc; mvec = nv;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        logic er;
        if (armed) begin
            er = (ms != 0) || por_r || ill_r || wd_r || osc_r || mwd || mosc || !s1;
            check(pin_drive == (ms == 1), "R2 pin drive", int'(pin_drive), int'(ms == 1));
            check(core_rst == er, "R4 core reset", int'(core_rst), int'(er));
            check(vec == mvec, "R6 vector", int'(vec), int'(mvec));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            report();
        end
    end

    task automatic pulse(input int which);
        case (which)
            0: por_r = 1'b1;
            1: ill_r = 1'b1;
            2: wd_r  = 1'b1;
            default: osc_r = 1'b1;
        endcase
        @(negedge clk);
        por_r = 1'b0; ill_r = 1'b0; wd_r = 1'b0; osc_r = 1'b0;
    endtask

    task automatic wait_done(input logic [1:0] expv, input string req);
        while (core_rst) @(negedge clk);
        check(vec == expv, req, int'(vec), int'(expv));
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(pin_drive == 1'b0, "R9 drive in reset", int'(pin_drive), 0);
        check(core_rst == 1'b0, "R9 core reset in reset", int'(core_rst), 0);
        check(vec == 2'b00, "R9 vector in reset", int'(vec), 0);
        rst = 1'b0;
        @(negedge clk);
        armed = 1'b1;

        // R1 power-on: immediate core reset, vector 00
        por_r = 1'b1;
        #1 check(core_rst == 1'b1, "R1 same-cycle reset", int'(core_rst), 1);
        @(negedge clk); por_r = 1'b0;
        check(pin_drive == 1'b1, "R2 drive starts", int'(pin_drive), 1);
        repeat (DRV) @(negedge clk);
        check(pin_drive == 1'b0 && core_rst == 1'b1, "R3 settle window", int'(pin_drive), 0);
        wait_done(2'b00, "R6 power-on vector");

        // watchdog
        pulse(2);
        wait_done(2'b01, "R6 watchdog vector");

        // both faults: oscillator wins
        wd_r = 1'b1; osc_r = 1'b1;
        @(negedge clk); wd_r = 1'b0; osc_r = 1'b0;
        wait_done(2'b10, "R6 oscillator priority");

        // illegal access
        pulse(1);
        wait_done(2'b00, "R1 illegal access vector");

        // R7 request during drive is kept
        pulse(0);
        repeat (4) @(negedge clk);
        pulse(2);
        wait_done(2'b01, "R7 sticky watchdog");

        // R8 short external low, delayed start
        ext_low = 1'b1;
        @(negedge clk);
        check(core_rst == 1'b0, "R8 one edge not enough", int'(core_rst), 0);
        @(negedge clk);
        check(core_rst == 1'b1, "R8 start after sync", int'(core_rst), 1);
        ext_low = 1'b0;
        wait_done(2'b00, "R8 external vector");

        // R5 long external hold with oscillator pending
        pulse(3);
        ext_low = 1'b1;
        repeat (DRV + SET + 8) @(negedge clk);
        check(core_rst == 1'b1, "R5 held by pin", int'(core_rst), 1);
        ext_low = 1'b0;
        wait_done(2'b00, "R5 pin-low vector ignores flags");
        check(core_rst == 1'b0, "R7 flags cleared after hold", int'(core_rst), 0);

        // R7 request in the exit cycle restarts
        pulse(0);
        while (!(ms == 2 && mc == SET - 1)) @(negedge clk);
        wd_r = 1'b1;
        @(negedge clk); wd_r = 1'b0;
        check(core_rst == 1'b1, "R7 exit-cycle request restarts", int'(core_rst), 1);
        check(vec == 2'b00, "R6 vector of ended sequence", int'(vec), 0);
        @(negedge clk);
        check(pin_drive == 1'b1, "R7 restart drives pin", int'(pin_drive), 1);
        wait_done(2'b01, "R7 restart vector");

        repeat (4) @(negedge clk);
        report();
    end
endmodule